// File: doc/BRIEF.md
# Filtered Quadrature Decoder Front End

This block sits between an incremental encoder and a position counter. It takes the raw A, B and active-low index lines and turns them into single-cycle count-up, count-down and index-event pulses in the system clock domain. Each line first passes a two-flop synchronizer. A digital filter then samples it on a filter tick and accepts a new level only when two consecutive ticks agree. The tick runs at the system clock rate, or at half that rate when the prescale input is set. For correct filtering the tick rate must be at least four times the highest A frequency.

The filtered phases are decoded at one, two or four counts per quadrature cycle. In the clock-plus-direction mode, the synchronized but unfiltered A line is the count clock and B sets the direction. The index event can be qualified against the filtered A/B state (synchronous mode) or taken from the raw index edge (asynchronous mode). Clock-plus-direction mode always uses the asynchronous index behaviour.

Top module: `quad_front`

## Requirements
- R1: With `dec_mode` = 2'b11, every single-phase change of the filtered A/B pair gives one count. The order 00→10→11→01→00 (written as {A,B}) counts up, and the reverse order counts down.
- R2: With `dec_mode` = 2'b10, only edges of A count. An edge after which A and B differ counts up, an edge after which they are equal counts down, and B edges give no count.
- R3: With `dec_mode` = 2'b01, a rising A edge while B is low counts up, a falling A edge while B is low counts down, and every other edge gives no count.
- R4: With `dec_mode` = 2'b00, each rising edge of A counts, up when B is high and down when B is low. A is not filtered, so an A pulse one clock wide still counts. Changes of B alone, and falling edges of A, give no count.
- R5: With `fclk_half` low, a level on A, B or index that lasts only one clock is discarded. A level held for two clocks is accepted.
- R6: With `fclk_half` high, the filter ticks on every other clock. A two-clock pulse is discarded, and steady levels still decode normally.
- R7: In the quadrature modes, a filter update in which A and B change together gives no count.
- R8: With `idx_sync` high and a quadrature mode selected, one index event is produced when the filtered index is low while A equals B. Only one event is produced per low period of the index. A low index while A differs from B produces no event.
- R9: With `idx_sync` low, or with `dec_mode` = 2'b00, a falling edge of the synchronized index produces one event whatever the A/B state.
- R10: After reset all outputs are low. Every output is a pulse one clock wide, and `cnt_up` and `cnt_dn` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_mode | input | 2 | 00 clock/direction, 01 x1, 10 x2, 11 x4 |
| fclk_half | input | 1 | 1: filter tick runs at half the clock rate |
| idx_sync | input | 1 | 1: qualify index against the A/B state |
| enc_a | input | 1 | Encoder phase A, or count clock in clock/direction mode |
| enc_b | input | 1 | Encoder phase B, or direction in clock/direction mode |
| enc_idx_n | input | 1 | Encoder index, active low |
| cnt_up | output | 1 | One-cycle count-up pulse |
| cnt_dn | output | 1 | One-cycle count-down pulse |
| idx_evt | output | 1 | One-cycle qualified index pulse |

## Verification
A filtered quadrature count or synchronous index event follows the input change by two synchronizer cycles, two agreeing filter ticks and one output register. That is five clocks at full tick rate, and up to seven when the tick is halved. A clock/direction count or an asynchronous index event appears three clocks after the input changes. The bench holds every input state for sixteen clocks, which is longer than the worst case. It pushes the pulses each step should produce into a queue, and a monitor pops one entry for each pulse it samples on the falling clock edge. At the end of each hold window the bench checks that the queue is empty, so a missing pulse, an extra pulse or a pulse of the wrong kind is reported against the requirement that step exercises.

// File: rtl/quad_front.sv
module quad_front (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] dec_mode,
  input  logic       fclk_half,
  input  logic       idx_sync,
  input  logic       enc_a,
  input  logic       enc_b,
  input  logic       enc_idx_n,
  output logic       cnt_up,
  output logic       cnt_dn,
  output logic       idx_evt
);
  localparam logic [2:0] IDLE = 3'b100;

  logic [2:0] sy1, sy2, smp, flt, fpv;
  logic div_t, tick, nq_pa, idx_pv, armed;
  logic fa, fb, ea, eb, same;
  logic q4_up, q4_dn, q2_up, q2_dn, q1_up, q1_dn, nq_up, nq_dn;
  logic up_d, dn_d, sync_eff, sync_fire, async_fire;

  assign tick  = !fclk_half | div_t;
  assign fa    = flt[0];
  assign fb    = flt[1];
  assign ea    = fa ^ fpv[0];
  assign eb    = fb ^ fpv[1];
  assign same  = ~(fa ^ fb);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= IDLE; sy2 <= IDLE; smp <= IDLE; flt <= IDLE; fpv <= IDLE;
      div_t <= 1'b0;
    end else begin
      sy1   <= {enc_idx_n, enc_b, enc_a};
      sy2   <= sy1;
      div_t <= ~div_t;
      fpv   <= flt;
      if (tick) begin
        smp <= sy2;
        flt <= (sy2 & ~(sy2 ^ smp)) | (flt & (sy2 ^ smp));
      end
    end

  assign q4_up = (ea & ~eb & ~same) | (eb & ~ea & same);
  assign q4_dn = (ea & ~eb & same)  | (eb & ~ea & ~same);
  assign q2_up = ea & ~eb & ~same;
  assign q2_dn = ea & ~eb & same;
  assign q1_up = ea & ~eb & fa & ~fb;
  assign q1_dn = ea & ~eb & ~fa & ~fb;
  assign nq_up = sy2[0] & ~nq_pa & sy2[1];
  assign nq_dn = sy2[0] & ~nq_pa & ~sy2[1];

  always_comb
    case (dec_mode)
      2'b00:   begin up_d = nq_up; dn_d = nq_dn; end
      2'b01:   begin up_d = q1_up; dn_d = q1_dn; end
      2'b10:   begin up_d = q2_up; dn_d = q2_dn; end
      default: begin up_d = q4_up; dn_d = q4_dn; end
    endcase

  assign sync_eff   = idx_sync & (dec_mode != 2'b00);
  assign sync_fire  = armed & ~flt[2] & same;
  assign async_fire = idx_pv & ~sy2[2];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      nq_pa <= 1'b0; idx_pv <= 1'b1; armed <= 1'b1;
      cnt_up <= 1'b0; cnt_dn <= 1'b0; idx_evt <= 1'b0;
    end else begin
      nq_pa   <= sy2[0];
      idx_pv  <= sy2[2];
      armed   <= flt[2] | (armed & ~sync_fire);
      cnt_up  <= up_d;
      cnt_dn  <= dn_d;
      idx_evt <= sync_eff ? sync_fire : async_fire;
    end
endmodule

// File: rtl/quad_front_chk.sv
module quad_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] dec_mode,
  input logic       idx_sync,
  input logic       cnt_up,
  input logic       cnt_dn,
  input logic       idx_evt,
  input logic       fa,
  input logic       fb,
  input logic       fidx,
  input logic       syb
);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_up && cnt_dn));

  p_nq_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_mode == 2'b00 && $stable(dec_mode) && (cnt_up || cnt_dn)) |-> (cnt_up == $past(syb)));

  p_x1_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_up && $past(dec_mode) == 2'b01) |-> ($past(fa) && !$past(fb)));

  p_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_mode != 2'b00 && fa != $past(fa) && fb != $past(fb)) |=> !(cnt_up || cnt_dn));

  p_sync_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_evt && $past(idx_sync) && $past(dec_mode) != 2'b00) |-> (!$past(fidx) && $past(fa) == $past(fb)));
endmodule

bind quad_front quad_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dec_mode(dec_mode), .idx_sync(idx_sync),
  .cnt_up(cnt_up), .cnt_dn(cnt_dn), .idx_evt(idx_evt),
  .fa(flt[0]), .fb(flt[1]), .fidx(flt[2]), .syb(sy2[1])
);

// File: tb/quad_front_test.sv
module quad_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] dec_mode = 2'b11;
  logic fclk_half = 1'b0, idx_sync = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, enc_idx_n = 1'b1;
  logic cnt_up, cnt_dn, idx_evt;

  int tests = 0, fails = 0;
  byte exp_q[$];
  string tag_q[$];
  string cur_tag = "R10";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_front uut (
    .clk(clk), .rst_n(rst_n), .dec_mode(dec_mode), .fclk_half(fclk_half),
    .idx_sync(idx_sync), .enc_a(enc_a), .enc_b(enc_b), .enc_idx_n(enc_idx_n),
    .cnt_up(cnt_up), .cnt_dn(cnt_dn), .idx_evt(idx_evt)
  );

  task automatic see(byte c);
    byte e;
    string t;
    tests++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL %s: pulse %s seen, expected none", cur_tag, string'(c));
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e != c) begin
        fails++;
        $display("FAIL %s: pulse %s seen, expected %s", t, string'(c), string'(e));
      end
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (cnt_up)  see("U");
    if (cnt_dn)  see("D");
    if (idx_evt) see("I");
  end

  task automatic expect_s(string tag, string ex);
    cur_tag = tag;
    for (int i = 0; i < ex.len(); i++) begin
      exp_q.push_back(ex[i]);
      tag_q.push_back(tag);
    end
  endtask

  task automatic drain(string tag);
    repeat (HOLD) @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d pulses missing, expected 0 outstanding", tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic step(logic a, logic b, logic ix, string tag, string ex);
    @(negedge clk);
    expect_s(tag, ex);
    enc_a = a; enc_b = b; enc_idx_n = ix;
    drain(tag);
  endtask

  task automatic pulse_a(int w, string tag, string ex);
    @(negedge clk);
    expect_s(tag, ex);
    enc_a = 1'b1;
    repeat (w) @(negedge clk);
    enc_a = 1'b0;
    drain(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tests++;
    if (cnt_up || cnt_dn || idx_evt) begin
      fails++;
      $display("FAIL R10: outputs %b%b%b after reset, expected 000", cnt_up, cnt_dn, idx_evt);
    end

    // R1 x4 both directions
    dec_mode = 2'b11;
    step(1,0,1,"R1","U"); step(1,1,1,"R1","U"); step(0,1,1,"R1","U"); step(0,0,1,"R1","U");
    step(0,1,1,"R1","D"); step(1,1,1,"R1","D"); step(1,0,1,"R1","D"); step(0,0,1,"R1","D");

    // R2 x2
    dec_mode = 2'b10;
    step(1,0,1,"R2","U"); step(1,1,1,"R2","");  step(0,1,1,"R2","U"); step(0,0,1,"R2","");
    step(1,0,1,"R2","U"); step(0,0,1,"R2","D");

    // R3 x1
    dec_mode = 2'b01;
    step(1,0,1,"R3","U"); step(1,1,1,"R3","");  step(0,1,1,"R3","");  step(0,0,1,"R3","");
    step(1,0,1,"R3","U"); step(0,0,1,"R3","D");
    step(0,1,1,"R3","");  step(1,1,1,"R3","");  step(1,0,1,"R3","");  step(0,0,1,"R3","D");

    // R7 simultaneous change
    dec_mode = 2'b11;
    step(1,1,1,"R7",""); step(0,0,1,"R7","");

    // R5 filter at full tick rate
    pulse_a(1,"R5","");
    pulse_a(2,"R5","UD");

    // R6 half tick rate
    fclk_half = 1'b1;
    pulse_a(2,"R6","");
    step(1,0,1,"R6","U"); step(0,0,1,"R6","D");
    fclk_half = 1'b0;

    // R4 clock/direction
    dec_mode = 2'b00;
    step(0,1,1,"R4","");
    pulse_a(1,"R4","U");
    step(0,0,1,"R4","");
    pulse_a(1,"R4","D");
    step(1,0,1,"R4","D"); step(0,0,1,"R4","");

    // R8 synchronous index
    dec_mode = 2'b11; idx_sync = 1'b1;
    step(0,1,1,"R8","D");
    step(0,1,0,"R8","");  step(0,1,1,"R8","");
    step(0,0,1,"R8","U");
    step(0,0,0,"R8","I");
    step(1,0,0,"R8","U"); step(1,1,0,"R8","U");
    step(1,1,1,"R8","");  step(1,1,0,"R8","I"); step(1,1,1,"R8","");

    // R9 asynchronous index, and forced asynchronous in clock/direction mode
    idx_sync = 1'b0;
    step(0,1,1,"R9","U");
    step(0,1,0,"R9","I"); step(0,1,1,"R9","");
    dec_mode = 2'b00; idx_sync = 1'b1;
    step(0,1,0,"R9","I"); step(0,1,1,"R9","");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R10: watchdog expired, expected run to complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule